// File: doc/BRIEF.md
# Video Controller CPU Register Port

This block is the register file that a processor uses to talk to a tile-based video controller. The processor sees eight register slots that repeat through an address window. The block carries the side effects of the slots that have them. A read of status clears the vertical-blank flag. Address writes are split into two halves by one shared toggle. The data slot reads and writes video memory at an address that steps by itself after each access.

Data reads are delayed by one deep buffer: each read returns the byte fetched by the read before it. The exception is the palette range, which is returned in the same access. The block also raises a one-cycle interrupt request when vertical blank begins, if the control register allows it. A write to a separate DMA address latches the source page for a sprite-memory copy and pulses a request to the DMA engine.

The bus is single-cycle. A read returns its data combinationally in the cycle of the strobe, and the side effects take hold at the following clock edge. Video memory is read combinationally at the current video address.

Top module: `vid_regport`

## Requirements
- R1: A register access is decoded only when the processor address lies in 0x2000..0x3FFF, with the slot given by the address modulo 8. Slot 0 is control, slot 2 is status, slot 5 is scroll, slot 6 is address and slot 7 is data. A write outside the window has no effect. Writes to slots 1, 3 and 4 have no effect. A read of any slot other than 2 or 7 returns 0.
- R2: A status read returns the vblank flag in bit 7 and zero in every other bit. After the read, the flag and the write toggle are cleared. If vblank_set is high in the same cycle, the flag stays set.
- R3: An address write with the toggle clear keeps data bits 5:0 as the high part of the address. An address write with the toggle set loads the full 14-bit video address as {high part, data}. Every address write and every scroll write inverts the toggle.
- R4: A data write drives vmem_we high for that cycle, with vmem_addr at the current video address and vmem_wdata equal to the processor data. The video address then advances by one step.
- R5: The step is 1 when control bit 2 is clear and 32 when it is set. The address wraps modulo 2^14, so 0x3FE0 plus 32 gives 0x0000.
- R6: A data read at a video address below 0x3F00 returns the buffered byte. The buffer then loads vmem_rdata at the current address, and the address advances by one step.
- R7: A data read at a video address of 0x3F00 or above returns vmem_rdata in the same cycle. The buffer is still refilled and the address still advances.
- R8: nmi_out pulses high for exactly one cycle, in the cycle after vblank_set, when the vblank flag was clear and control bit 7 was set. It stays low when the flag was already set or when the enable bit is clear.
- R9: A processor write to 0x4014 loads dma_page with the data. It raises dma_req for exactly the next cycle. A write to any other address leaves both unchanged.
- R10: After reset, the video address, toggle, vblank flag, read buffer, control bits, nmi_out, dma_req and dma_page are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid in the cycle of cpu_rd |
| vmem_addr | output | 14 | Current video memory address |
| vmem_wdata | output | 8 | Video memory write data |
| vmem_we | output | 1 | Video memory write enable |
| vmem_rdata | input | 8 | Video memory read data at vmem_addr |
| vblank_set | input | 1 | Pulse from the timing logic when vertical blank begins |
| nmi_out | output | 1 | Interrupt request pulse to the processor |
| dma_page | output | 8 | Source page for a sprite-memory DMA |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The bench goes after several corner cases, and each has a clear symptom when the design gets it wrong.

A design that forgets to clear the toggle on a status read would take the next high half as a low half and load a wrong address. The same happens if a scroll write does not flip the toggle. The bench also checks the one-read lag of the data buffer against the palette bypass at 0x3F00. A design that returned the fresh byte everywhere, or the stale byte for the palette, would be off by one read.

The step of 32 is driven across the 14-bit wrap, where a wider adder would walk past 0x3FFF. vblank_set is driven twice in a row, which must give only one interrupt. It is also driven together with a status read, where the set must win. Accesses just outside the window, and at 0x4015 beside the DMA address, must change nothing.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  parameter int VAW = 14;
  parameter int DW  = 8;
  localparam int HIW = VAW - DW;

  typedef enum logic [2:0] {
    SL_CTRL = 3'd0,
    SL_MASK = 3'd1,
    SL_STAT = 3'd2,
    SL_SPRA = 3'd3,
    SL_SPRD = 3'd4,
    SL_SCRL = 3'd5,
    SL_ADDR = 3'd6,
    SL_DATA = 3'd7
  } slot_e;

  localparam logic [VAW-1:0] PAL_BASE = 14'h3F00;

  function automatic logic [VAW-1:0] vrp_step(input logic inc32);
    return inc32 ? VAW'(32) : VAW'(1);
  endfunction

  function automatic logic [VAW-1:0] vrp_advance(input logic [VAW-1:0] a, input logic inc32);
    return a + vrp_step(inc32);
  endfunction

  function automatic logic vrp_is_pal(input logic [VAW-1:0] a);
    return a >= PAL_BASE;
  endfunction
endpackage

// File: rtl/vrp_decode.sv
module vrp_decode #(
  parameter int AW = 16,
  parameter logic [15:0] WIN_BASE = 16'h2000,
  parameter logic [15:0] WIN_LAST = 16'h3FFF,
  parameter logic [15:0] DMA_ADDR = 16'h4014,
  parameter int NSLOT = 8
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic          ev_ctrl_wr,
  output logic          ev_stat_rd,
  output logic          ev_toggle_wr,
  output logic          ev_addr_wr,
  output logic          ev_data_wr,
  output logic          ev_data_rd,
  output logic          ev_dma_wr
);
  import vrp_pkg::*;
  localparam int SW = $clog2(NSLOT);

  logic             in_win;
  logic [SW-1:0]    slot;
  logic [NSLOT-1:0] slot_hit;

  assign in_win = (cpu_addr >= AW'(WIN_BASE)) && (cpu_addr <= AW'(WIN_LAST));
  assign slot   = cpu_addr[SW-1:0];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_hit[i] = in_win && (slot == SW'(i));
  end

  assign ev_ctrl_wr   = cpu_wr && slot_hit[SL_CTRL];
  assign ev_stat_rd   = cpu_rd && slot_hit[SL_STAT];
  assign ev_addr_wr   = cpu_wr && slot_hit[SL_ADDR];
  assign ev_toggle_wr = cpu_wr && (slot_hit[SL_SCRL] || slot_hit[SL_ADDR]);
  assign ev_data_wr   = cpu_wr && slot_hit[SL_DATA];
  assign ev_data_rd   = cpu_rd && slot_hit[SL_DATA];
  assign ev_dma_wr    = cpu_wr && (cpu_addr == AW'(DMA_ADDR));
endmodule

// File: rtl/vrp_vaddr.sv
module vrp_vaddr (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_toggle_wr,
  input  logic                    ev_addr_wr,
  input  logic                    ev_stat_rd,
  input  logic                    ev_data_acc,
  input  logic                    inc32,
  input  logic [vrp_pkg::DW-1:0]  wdata,
  output logic [vrp_pkg::VAW-1:0] vaddr,
  output logic                    toggle
);
  import vrp_pkg::*;

  logic [HIW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle <= 1'b0;
    end else if (ev_stat_rd) begin
      toggle <= 1'b0;
    end else if (ev_toggle_wr) begin
      toggle <= ~toggle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (ev_addr_wr && !toggle) begin
      hi_q <= wdata[HIW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr <= '0;
    end else if (ev_addr_wr && toggle) begin
      vaddr <= {hi_q, wdata};
    end else if (ev_data_acc) begin
      vaddr <= vrp_advance(vaddr, inc32);
    end
  end
endmodule

// File: rtl/vrp_status.sv
module vrp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_set,
  input  logic ev_stat_rd,
  input  logic ev_ctrl_wr,
  input  logic bit_inc,
  input  logic bit_nmi,
  output logic vbl_flag,
  output logic inc32,
  output logic nmi_en,
  output logic nmi_out
);
  logic vbl_rise;

  assign vbl_rise = vblank_set && !vbl_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbl_flag <= 1'b0;
    end else if (vblank_set) begin
      vbl_flag <= 1'b1;
    end else if (ev_stat_rd) begin
      vbl_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc32  <= 1'b0;
      nmi_en <= 1'b0;
    end else if (ev_ctrl_wr) begin
      inc32  <= bit_inc;
      nmi_en <= bit_nmi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_out <= 1'b0;
    end else begin
      nmi_out <= vbl_rise && nmi_en;
    end
  end
endmodule

// File: rtl/vrp_rdpath.sv
module vrp_rdpath (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_stat_rd,
  input  logic                    ev_data_rd,
  input  logic                    ev_dma_wr,
  input  logic                    vbl_flag,
  input  logic [vrp_pkg::VAW-1:0] vaddr,
  input  logic [vrp_pkg::DW-1:0]  vmem_rdata,
  input  logic [vrp_pkg::DW-1:0]  wdata,
  output logic [vrp_pkg::DW-1:0]  cpu_rdata,
  output logic [vrp_pkg::DW-1:0]  rd_buf,
  output logic [vrp_pkg::DW-1:0]  dma_page,
  output logic                    dma_req
);
  import vrp_pkg::*;

  always_comb begin
    cpu_rdata = '0;
    if (ev_stat_rd) begin
      cpu_rdata = {vbl_flag, {(DW-1){1'b0}}};
    end else if (ev_data_rd) begin
      cpu_rdata = vrp_is_pal(vaddr) ? vmem_rdata : rd_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_buf <= '0;
    end else if (ev_data_rd) begin
      rd_buf <= vmem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_page <= '0;
      dma_req  <= 1'b0;
    end else begin
      dma_req <= ev_dma_wr;
      if (ev_dma_wr) dma_page <= wdata;
    end
  end
endmodule

// File: rtl/vid_regport.sv
module vid_regport #(
  parameter int AW = 16,
  parameter logic [15:0] WIN_BASE = 16'h2000,
  parameter logic [15:0] WIN_LAST = 16'h3FFF,
  parameter logic [15:0] DMA_ADDR = 16'h4014
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           cpu_addr,
  input  logic [vrp_pkg::DW-1:0]  cpu_wdata,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  output logic [vrp_pkg::DW-1:0]  cpu_rdata,
  output logic [vrp_pkg::VAW-1:0] vmem_addr,
  output logic [vrp_pkg::DW-1:0]  vmem_wdata,
  output logic                    vmem_we,
  input  logic [vrp_pkg::DW-1:0]  vmem_rdata,
  input  logic                    vblank_set,
  output logic                    nmi_out,
  output logic [vrp_pkg::DW-1:0]  dma_page,
  output logic                    dma_req
);
  import vrp_pkg::*;
  localparam int BIT_INC = 2;
  localparam int BIT_NMI = DW - 1;

  logic ev_ctrl_wr, ev_stat_rd, ev_toggle_wr, ev_addr_wr;
  logic ev_data_wr, ev_data_rd, ev_dma_wr;
  logic vbl_flag, inc32, nmi_en, toggle;
  logic [VAW-1:0] vaddr;
  logic [DW-1:0]  rd_buf;

  vrp_decode #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST),
               .DMA_ADDR(DMA_ADDR), .NSLOT(8)) u_dec (
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .ev_ctrl_wr(ev_ctrl_wr), .ev_stat_rd(ev_stat_rd),
    .ev_toggle_wr(ev_toggle_wr), .ev_addr_wr(ev_addr_wr),
    .ev_data_wr(ev_data_wr), .ev_data_rd(ev_data_rd), .ev_dma_wr(ev_dma_wr)
  );

  vrp_status u_stat (
    .clk(clk), .rst_n(rst_n), .vblank_set(vblank_set),
    .ev_stat_rd(ev_stat_rd), .ev_ctrl_wr(ev_ctrl_wr),
    .bit_inc(cpu_wdata[BIT_INC]), .bit_nmi(cpu_wdata[BIT_NMI]),
    .vbl_flag(vbl_flag), .inc32(inc32), .nmi_en(nmi_en), .nmi_out(nmi_out)
  );

  vrp_vaddr u_va (
    .clk(clk), .rst_n(rst_n), .ev_toggle_wr(ev_toggle_wr),
    .ev_addr_wr(ev_addr_wr), .ev_stat_rd(ev_stat_rd),
    .ev_data_acc(ev_data_wr || ev_data_rd), .inc32(inc32),
    .wdata(cpu_wdata), .vaddr(vaddr), .toggle(toggle)
  );

  vrp_rdpath u_rd (
    .clk(clk), .rst_n(rst_n), .ev_stat_rd(ev_stat_rd),
    .ev_data_rd(ev_data_rd), .ev_dma_wr(ev_dma_wr), .vbl_flag(vbl_flag),
    .vaddr(vaddr), .vmem_rdata(vmem_rdata), .wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .rd_buf(rd_buf), .dma_page(dma_page),
    .dma_req(dma_req)
  );

  assign vmem_addr  = vaddr;
  assign vmem_wdata = cpu_wdata;
  assign vmem_we    = ev_data_wr;
endmodule

// File: rtl/vid_regport_chk.sv
module vid_regport_chk (
  input logic                    clk,
  input logic                    rst_n,
  input logic [vrp_pkg::DW-1:0]  cpu_wdata,
  input logic                    vblank_set,
  input logic                    ev_stat_rd,
  input logic                    ev_toggle_wr,
  input logic                    ev_data_rd,
  input logic                    ev_dma_wr,
  input logic                    vbl_flag,
  input logic                    toggle,
  input logic                    inc32,
  input logic [vrp_pkg::VAW-1:0] vmem_addr,
  input logic [vrp_pkg::DW-1:0]  vmem_rdata,
  input logic [vrp_pkg::DW-1:0]  rd_buf,
  input logic                    vmem_we,
  input logic                    nmi_out,
  input logic [vrp_pkg::DW-1:0]  dma_page,
  input logic                    dma_req
);
  import vrp_pkg::*;

  // R2
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_rd && !vblank_set |=> !vbl_flag && !toggle);

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_toggle_wr |=> toggle != $past(toggle));

  // R4
  data_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vmem_we |=> vmem_addr == vrp_advance($past(vmem_addr), $past(inc32)));

  // R6
  buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_rd |=> rd_buf == $past(vmem_rdata));

  // R8
  nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> $past(vblank_set) && !$past(vbl_flag));

  // R9
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(ev_dma_wr) && dma_page == $past(cpu_wdata));
endmodule

bind vid_regport vid_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata), .vblank_set(vblank_set),
  .ev_stat_rd(ev_stat_rd), .ev_toggle_wr(ev_toggle_wr),
  .ev_data_rd(ev_data_rd), .ev_dma_wr(ev_dma_wr), .vbl_flag(vbl_flag),
  .toggle(toggle), .inc32(inc32), .vmem_addr(vmem_addr),
  .vmem_rdata(vmem_rdata), .rd_buf(rd_buf), .vmem_we(vmem_we),
  .nmi_out(nmi_out), .dma_page(dma_page), .dma_req(dma_req)
);

// File: tb/vid_regport_tb_top.sv
module vid_regport_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, vblank_set = 1'b0;
  logic [7:0]  cpu_rdata, vmem_wdata, vmem_rdata, dma_page;
  logic [13:0] vmem_addr;
  logic        vmem_we, nmi_out, dma_req;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model state
  int m_vaddr, m_hi, m_buf, m_page;
  bit m_tog, m_vbl, m_inc32, m_nmien, m_nmi, m_dma;

  always #10 clk = ~clk;

  function automatic int memf(int a);
    return ((a & 255) ^ ((a >> 6) & 252) ^ 3) & 255;
  endfunction

  assign vmem_rdata = 8'(memf(int'(vmem_addr)));

  vid_regport dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .vmem_addr(vmem_addr), .vmem_wdata(vmem_wdata), .vmem_we(vmem_we),
    .vmem_rdata(vmem_rdata), .vblank_set(vblank_set), .nmi_out(nmi_out),
    .dma_page(dma_page), .dma_req(dma_req)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_vaddr = 0; m_hi = 0; m_buf = 0; m_page = 0;
    m_tog = 0; m_vbl = 0; m_inc32 = 0; m_nmien = 0; m_nmi = 0; m_dma = 0;
  endtask

  // one bus cycle: drive, compare against the model, then advance the model
  task automatic tick(string tag, bit rd, bit wr, int addr, int wd, bit vs);
    bit inwin;
    int slot, exp_rd, step;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = 16'(addr); cpu_wdata = 8'(wd);
    vblank_set = vs;
    #5;
    inwin = (addr >= 'h2000) && (addr <= 'h3FFF);
    slot  = addr % 8;
    step  = m_inc32 ? 32 : 1;
    cmp(tag, "vmem_addr", int'(vmem_addr), m_vaddr);
    cmp(tag, "vmem_we", int'(vmem_we), int'(wr && inwin && slot == 7));
    if (wr && inwin && slot == 7) cmp(tag, "vmem_wdata", int'(vmem_wdata), wd);
    cmp(tag, "nmi_out", int'(nmi_out), int'(m_nmi));
    cmp(tag, "dma_req", int'(dma_req), int'(m_dma));
    cmp(tag, "dma_page", int'(dma_page), m_page);
    if (rd) begin
      exp_rd = 0;
      if (inwin && slot == 2) exp_rd = m_vbl ? 128 : 0;
      else if (inwin && slot == 7) exp_rd = (m_vaddr > 'h3EFF) ? memf(m_vaddr) : m_buf;
      cmp(tag, "cpu_rdata", int'(cpu_rdata), exp_rd);
    end
    // next state
    m_nmi = vs && !m_vbl && m_nmien;
    m_dma = wr && addr == 'h4014;
    if (m_dma) m_page = wd;
    if (vs) m_vbl = 1;
    else if (rd && inwin && slot == 2) m_vbl = 0;
    if (rd && inwin && slot == 2) m_tog = 0;
    if (wr && inwin) begin
      case (slot)
        0: begin m_inc32 = wd[2]; m_nmien = wd[7]; end
        5: m_tog = !m_tog;
        6: begin
             if (!m_tog) m_hi = wd & 63;
             else m_vaddr = m_hi * 256 + wd;
             m_tog = !m_tog;
           end
        7: m_vaddr = (m_vaddr + step) % 16384;
        default: ;
      endcase
    end
    if (rd && inwin && slot == 7) begin
      m_buf = memf(m_vaddr);
      m_vaddr = (m_vaddr + step) % 16384;
    end
  endtask

  task automatic wr(string tag, int a, int d);  tick(tag, 0, 1, a, d, 0); endtask
  task automatic rd(string tag, int a);         tick(tag, 1, 0, a, 0, 0); endtask
  task automatic idle(string tag);              tick(tag, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10 reset state
    idle("R10"); rd("R10", 'h2002); rd("R10", 'h2007);
    // R3 two-step address load, R4 data writes step 1
    wr("R3", 'h2006, 'hE1); wr("R3", 'h2006, 'h08);
    wr("R4", 'h2007, 'h11); wr("R4", 'h2007, 'h22); wr("R4", 'h200F, 'h33);
    // R1 control via mirrored address, R5 step 32
    wr("R1", 'h3FF8, 'h04);
    wr("R5", 'h2007, 'h44); wr("R5", 'h2007, 'h55);
    // R5 wrap at 14 bits
    wr("R5", 'h2006, 'h3F); wr("R5", 'h2006, 'hE0); wr("R5", 'h2007, 'h66);
    idle("R5");
    // R6 buffered reads, step 1
    wr("R6", 'h2000, 'h00);
    wr("R6", 'h2006, 'h21); wr("R6", 'h2006, 'h30);
    rd("R6", 'h2007); rd("R6", 'h2007); rd("R6", 'h3FFF);
    // R7 palette bypass
    wr("R7", 'h2006, 'h3F); wr("R7", 'h2006, 'h05);
    rd("R7", 'h2007); rd("R7", 'h2007);
    wr("R7", 'h2006, 'h3E); wr("R7", 'h2006, 'hFF); rd("R7", 'h2007); rd("R7", 'h2007);
    // R2 status read resets the toggle mid-pair
    wr("R2", 'h2006, 'h12); rd("R2", 'h2002);
    wr("R2", 'h2006, 'h05); wr("R2", 'h2006, 'h67); idle("R2");
    // R3 scroll write shares the toggle
    wr("R3", 'h2005, 'h99); wr("R3", 'h2006, 'h44);
    wr("R3", 'h2006, 'h0A); wr("R3", 'h2006, 'hBC); idle("R3");
    // R1 ignored slots and out-of-window accesses
    wr("R1", 'h1FFE, 'h01); wr("R1", 'h4006, 'h01); wr("R1", 'h2001, 'hFF);
    wr("R1", 'h2003, 'hFF); wr("R1", 'h2004, 'hFF); wr("R1", 'h1FF8, 'h84);
    rd("R1", 'h2000); rd("R1", 'h2004); rd("R1", 'h1FFF);
    wr("R1", 'h2007, 'h77); idle("R1");
    // R8 no interrupt while disabled, flag visible then cleared
    tick("R8", 0, 0, 0, 0, 1); idle("R8");
    rd("R2", 'h2002); rd("R2", 'h2002);
    // R8 enabled: one pulse, none while flag is already set
    wr("R8", 'h2000, 'h80);
    tick("R8", 0, 0, 0, 0, 1); tick("R8", 0, 0, 0, 0, 1); idle("R8"); idle("R8");
    // R2 set wins over a same-cycle status read
    tick("R2", 1, 0, 'h2002, 0, 1); rd("R2", 'h200A); rd("R2", 'h2002);
    tick("R8", 0, 0, 0, 0, 1); idle("R8"); idle("R8");
    // R9 DMA page latch and pulse
    wr("R9", 'h4014, 'h07); idle("R9"); wr("R9", 'h4015, 'h09); idle("R9");
    wr("R9", 'h4014, 'hC2); wr("R9", 'h4014, 'h3D); idle("R9"); idle("R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule